// File: doc/BRIEF.md
# Two-Port Audio Interrupt Controller

This block gathers the transfer events of two audio ports. Each port has an output direction and an input direction, which gives four event sources. Each event arrives as a single-cycle pulse from the FIFO logic of its port.

Every event sets a sticky pending bit, whether or not that source is masked. A pending bit drives the shared CPU interrupt line only when two separate mask registers both enable that source. Software clears pending bits in one of two ways:
- by writing zeros into the status register;
- by driving the interrupt-clear bit of a soft-reset register low and then writing it back high.

The soft-reset register also holds three active-low reset controls: one global and one for each port. The controller brings these out as pins for the neighbouring logic.

All registers sit on a simple synchronous register bus. A write is taken on the clock edge where select and write are both high. Read data is registered and appears one cycle after the request. The bus has no wait states and no back-pressure: every access completes in one cycle.

Top module: `audirq_ctrl`

## Requirements
- R1: After reset the registers and outputs are as follows:
  - the status, mask and enable-mask registers read 0;
  - the soft-reset register reads 0x00001111;
  - `irq` is 0;
  - the three reset outputs are 1.
- R2: Each source has a fixed bit position: port A output (src_pulse[0]) at bit 0, port A input (src_pulse[1]) at bit 4, port B output (src_pulse[2]) at bit 8 and port B input (src_pulse[3]) at bit 12. The status register is at word address 0. A pulse sets its bit on the next clock edge, whatever the masks hold.
- R3: A status bit stays set until it is cleared by a status write (R4) or by the interrupt-clear bit (R6). Further pulses leave it set.
- R4: A write to the status register behaves as follows:
  - it clears each source bit whose write-data bit is 0;
  - it leaves each source bit whose write-data bit is 1 unchanged;
  - if a pulse arrives in the same cycle, the pulse wins and its bit ends up set.
- R5: `irq` goes to 1 one clock edge after a status bit is set whose bit is also set in the mask register (word address 1) and in the enable-mask register (word address 2). If either mask lacks the bit, `irq` stays 0.
- R6: The soft-reset register is at word address 3, and bit 4 of it is the interrupt-clear bit. While bit 4 is 0:
  - all status bits are cleared;
  - incoming pulses are ignored.
  Setting bit 4 back to 1 lets pulses set status bits again.
- R7: Soft-reset bit 0 drives `glob_srst_n`, bit 8 drives `porta_srst_n` and bit 12 drives `portb_srst_n`. Each output takes its new value on the edge that takes the write.
- R8: Only write-data bits 23:0 are stored. Read-data bits 31:24 are always 0. The mask and enable-mask registers store and return all 24 bits.
- R9: Read data appears one cycle after the request. Word addresses 4 and above read 0, and writes to them change nothing.
- R10: Status and soft-reset bits outside positions 0, 4, 8 and 12 read 0 and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data (bits 23:0 used) |
| bus_rdata | output | 32 | Registered read data |
| src_pulse | input | 4 | Event pulses: A out, A in, B out, B in |
| irq | output | 1 | Shared interrupt line to the CPU |
| glob_srst_n | output | 1 | Global soft reset, active low |
| porta_srst_n | output | 1 | Port A soft reset, active low |
| portb_srst_n | output | 1 | Port B soft reset, active low |

## Verification
Each result has a fixed delay after its stimulus:
- a pulse reaches the status register on the next edge;
- `irq` follows one edge after that, so it is due two edges after the pulse;
- read data is due one edge after the request;
- the reset outputs change on the write edge itself.

The bench drives inputs on falling edges and samples on falling edges, so each result is checked exactly at the cycle it is due. Right after a pulse, the bench also checks that `irq` is still low, which confirms the extra register stage.

// File: rtl/audirq_pkg.sv
package audirq_pkg;
  localparam int NSRC      = 4;
  localparam int SLOT_GAP  = 4;
  localparam int FIELD_W   = NSRC * SLOT_GAP;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_ENMASK = 2'd2,
    REG_SRST   = 2'd3
  } reg_sel_e;

  // slot indices inside the soft-reset register
  localparam int SR_GLOBAL = 0;
  localparam int SR_IRQCLR = 1;
  localparam int SR_PORTA  = 2;
  localparam int SR_PORTB  = 3;

  function automatic logic [FIELD_W-1:0] spread_slots(input logic [NSRC-1:0] s);
    logic [FIELD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NSRC; i++) w[i*SLOT_GAP] = s[i];
    return w;
  endfunction

  function automatic logic [NSRC-1:0] pick_slots(input logic [FIELD_W-1:0] w);
    logic [NSRC-1:0] s;
    for (int i = 0; i < NSRC; i++) s[i] = w[i*SLOT_GAP];
    return s;
  endfunction
endpackage

// File: rtl/audirq_regs.sv
module audirq_regs
  import audirq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int BUS_W   = 32,
  parameter int VALID_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NSRC-1:0]    st_q,
  output logic [VALID_W-1:0] msk_q,
  output logic [VALID_W-1:0] en_q,
  output logic [NSRC-1:0]    srst_q,
  output logic               st_wr,
  output logic [NSRC-1:0]    st_keep
);
  localparam logic [NSRC-1:0] SRST_INIT = '1;

  logic               in_map;
  logic [SEL_W-1:0]   sel_idx;
  logic [VALID_W-1:0] wd_v;
  logic               wr_go, rd_go;
  logic [BUS_W-1:0]   rd_word;

  assign in_map  = ((bus_addr >> SEL_W) == '0);
  assign sel_idx = bus_addr[SEL_W-1:0];
  assign wd_v    = bus_wdata[VALID_W-1:0];
  assign wr_go   = bus_sel && bus_we && in_map;
  assign rd_go   = bus_sel && !bus_we;

  assign st_wr   = wr_go && (reg_sel_e'(sel_idx) == REG_STATUS);
  assign st_keep = pick_slots(wd_v[FIELD_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q  <= '0;
      en_q   <= '0;
      srst_q <= SRST_INIT;
    end else if (wr_go) begin
      case (reg_sel_e'(sel_idx))
        REG_MASK:   msk_q  <= wd_v;
        REG_ENMASK: en_q   <= wd_v;
        REG_SRST:   srst_q <= pick_slots(wd_v[FIELD_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    if (in_map) begin
      case (reg_sel_e'(sel_idx))
        REG_STATUS: rd_word[FIELD_W-1:0] = spread_slots(st_q);
        REG_MASK:   rd_word[VALID_W-1:0] = msk_q;
        REG_ENMASK: rd_word[VALID_W-1:0] = en_q;
        REG_SRST:   rd_word[FIELD_W-1:0] = spread_slots(srst_q);
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_word;
  end

  generate
    if (BUS_W > VALID_W) begin : g_hi_chk
      assert_rdata_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:VALID_W] == '0);
    end
  endgenerate

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !in_map) |=> ($stable(msk_q) && $stable(en_q) && $stable(srst_q)));
endmodule

// File: rtl/audirq_status.sv
module audirq_status
  import audirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            st_wr,
  input  logic [NSRC-1:0] st_keep,
  input  logic            clr_hold,
  output logic [NSRC-1:0] st_q
);
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic drop;
      assign drop = st_wr && !st_keep[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            st_q[i] <= 1'b0;
        else if (clr_hold)     st_q[i] <= 1'b0;
        else if (src_pulse[i]) st_q[i] <= 1'b1;
        else if (drop)         st_q[i] <= 1'b0;
      end

      assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse[i] && !clr_hold) |=> st_q[i]);

      assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[i] && !clr_hold && !drop) |=> st_q[i]);
    end
  endgenerate

  assert_clear_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hold |=> (st_q == '0));
endmodule

// File: rtl/audirq_irq.sv
module audirq_irq
  import audirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] st_q,
  input  logic [NSRC-1:0] msk_src,
  input  logic [NSRC-1:0] en_src,
  output logic            irq
);
  logic [NSRC-1:0] qual;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_qual
      assign qual[i] = st_q[i] & msk_src[i] & en_src[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |qual;
  end

  assert_masks_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((msk_src & en_src) == '0) |=> !irq);

  assert_irq_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |=> !irq);
endmodule

// File: rtl/audirq_ctrl.sv
module audirq_ctrl
  import audirq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int BUS_W   = 32,
  parameter int VALID_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NSRC-1:0]   src_pulse,
  output logic              irq,
  output logic              glob_srst_n,
  output logic              porta_srst_n,
  output logic              portb_srst_n
);
  logic [VALID_W-1:0] msk_q, en_q;
  logic [NSRC-1:0]    srst_q, st_q, st_keep;
  logic               st_wr;

  audirq_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .VALID_W(VALID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_q(st_q), .msk_q(msk_q), .en_q(en_q), .srst_q(srst_q),
    .st_wr(st_wr), .st_keep(st_keep)
  );

  audirq_status u_status (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .st_wr(st_wr),
    .st_keep(st_keep), .clr_hold(!srst_q[SR_IRQCLR]), .st_q(st_q)
  );

  audirq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .st_q(st_q),
    .msk_src(pick_slots(msk_q[FIELD_W-1:0])),
    .en_src(pick_slots(en_q[FIELD_W-1:0])),
    .irq(irq)
  );

  assign glob_srst_n  = srst_q[SR_GLOBAL];
  assign porta_srst_n = srst_q[SR_PORTA];
  assign portb_srst_n = srst_q[SR_PORTB];

  assert_srst_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(3)) |=>
      (porta_srst_n == $past(bus_wdata[8]) && portb_srst_n == $past(bus_wdata[12])
       && glob_srst_n == $past(bus_wdata[0])));
endmodule

// File: tb/audirq_ctrl_bench.sv
module audirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_pulse = '0;
  logic        irq, glob_srst_n, porta_srst_n, portb_srst_n;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  audirq_ctrl u_audirq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_pulse(src_pulse), .irq(irq), .glob_srst_n(glob_srst_n),
    .porta_srst_n(porta_srst_n), .portb_srst_n(portb_srst_n)
  );

  // {src[3:0], mask slots[3:0], enable slots[3:0], expected irq}
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0001, 4'b0001, 4'b0001, 1'b1},
    {4'b0001, 4'b0001, 4'b0000, 1'b0},
    {4'b0001, 4'b0000, 4'b0001, 1'b0},
    {4'b0010, 4'b0010, 4'b0010, 1'b1},
    {4'b0100, 4'b1011, 4'b1111, 1'b0},
    {4'b1000, 4'b1000, 4'b1000, 1'b1},
    {4'b0101, 4'b0100, 4'b0100, 1'b1},
    {4'b0000, 4'b1111, 4'b1111, 1'b0},
    {4'b1111, 4'b0000, 4'b1111, 1'b0}
  };

  function automatic logic [31:0] slots(input logic [3:0] s);
    return {19'd0, s[3], 3'd0, s[2], 3'd0, s[1], 3'd0, s[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] s);
    @(negedge clk);
    src_pulse = s;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 srst outs", {29'd0, glob_srst_n, porta_srst_n, portb_srst_n}, 32'd7);
    rd(4'd0, d); check("R1 status", d, 32'd0);
    rd(4'd1, d); check("R1 mask", d, 32'd0);
    rd(4'd2, d); check("R1 enmask", d, 32'd0);
    rd(4'd3, d); check("R1 srst reg", d, 32'h0000_1111);

    // table: R2 positions, R5 dual-mask qualification
    for (int v = 0; v < NV; v++) begin
      logic [3:0] s, m, e;
      logic ex;
      {s, m, e, ex} = VEC[v];
      wr(4'd0, 32'd0);
      wr(4'd1, slots(m));
      wr(4'd2, slots(e));
      @(negedge clk);
      check("R5 irq idle", {31'd0, irq}, 32'd0);
      pulse(s);
      check("R5 irq latency", {31'd0, irq}, 32'd0);
      @(negedge clk);
      check("R5 irq", {31'd0, irq}, {31'd0, ex});
      rd(4'd0, d);
      check("R2 status", d, slots(s));
    end

    // R3 sticky, R4 write semantics
    wr(4'd0, 32'd0);
    wr(4'd1, 32'h1111); wr(4'd2, 32'h1111);
    pulse(4'b0011);
    repeat (5) @(negedge clk);
    pulse(4'b0001);
    rd(4'd0, d); check("R3 sticky", d, 32'h0011);
    wr(4'd0, 32'h0000_0011);
    rd(4'd0, d); check("R4 write ones keep", d, 32'h0011);
    wr(4'd0, 32'h0000_0010);
    rd(4'd0, d); check("R4 zero clears bit0", d, 32'h0010);
    check("R5 irq still up", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'd0);
    @(negedge clk);
    check("R5 irq drops", {31'd0, irq}, 32'd0);
    // pulse and clear in same cycle: pulse wins
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4'd0; bus_wdata = 32'd0; src_pulse = 4'b0100;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; src_pulse = '0;
    rd(4'd0, d); check("R4 pulse beats clear", d, 32'h0100);

    // R10 non-source bits
    wr(4'd0, 32'd0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R10 status others", d, 32'd0);

    // R6 interrupt-clear hold
    pulse(4'b1001);
    wr(4'd3, 32'h0000_1101);
    @(negedge clk);
    rd(4'd0, d); check("R6 cleared", d, 32'd0);
    pulse(4'b1111);
    rd(4'd0, d); check("R6 pulses ignored", d, 32'd0);
    check("R6 irq low", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'h0000_1111);
    pulse(4'b0010);
    rd(4'd0, d); check("R6 resumes", d, 32'h0010);

    // R7 reset outputs
    wr(4'd3, 32'h0000_0011);
    check("R7 ports low", {29'd0, glob_srst_n, porta_srst_n, portb_srst_n}, 32'd4);
    wr(4'd3, 32'h00FF_1110);
    check("R7 global low", {29'd0, glob_srst_n, porta_srst_n, portb_srst_n}, 32'd3);
    rd(4'd3, d); check("R10 srst others", d, 32'h0000_1110);
    wr(4'd3, 32'h0000_1111);

    // R8 24-bit data path
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d); check("R8 mask 24 bits", d, 32'h00FF_FFFF);
    wr(4'd2, 32'hA5C3_96E1);
    rd(4'd2, d); check("R8 enmask 24 bits", d, 32'h00C3_96E1);

    // R9 unmapped space
    wr(4'd5, 32'h0000_0000);
    wr(4'd9, 32'h0000_0000);
    rd(4'd5, d); check("R9 unmapped read", d, 32'd0);
    rd(4'd1, d); check("R9 mask untouched", d, 32'h00FF_FFFF);
    rd(4'd3, d); check("R9 srst untouched", d, 32'h0000_1111);

    summary();
  end
endmodule